// File: doc/BRIEF.md
# Transmit Byte Queue with Flushable Occupancy Count

This block is the outbound byte queue of a serial bus controller. Software writes bytes into it through the register bus, and the serial shifter drains them one at a time from the head. A live occupancy count follows every accepted write and every accepted removal. Software reads that count as a read-only word on the register bus.

Three controller events empty the queue in one cycle: the controller enable dropping, the raw transmit-abort status being set, and a slave bulk-transmit sequence being aborted. Each event zeroes the count and both pointers, so the next byte written becomes the new head. A queue write is only accepted when it targets the data offset. A write to the count's offset changes nothing.

Top module: `tx_level_fifo`

## Requirements
- R1: After a synchronous active-low reset, the count is 0, `q_empty` is 1 and `q_full` is 0, and the count word reads as 0.
- R2: A register write to data offset 0x10, while no flush is active and the queue is not full, stores `bus_wr_data` and raises the count by one on that clock edge.
- R3: A pop request while the queue is not empty removes the head byte and lowers the count by one. `shf_data` always presents the oldest unremoved byte, so bytes leave in the order they were written.
- R4: An accepted push and an accepted pop in the same cycle leave the count unchanged.
- R5: With DEPTH (64) entries held, a further push is ignored: the count stays at 64 and the stored bytes are unchanged.
- R6: A pop request on an empty queue is ignored and the count stays 0.
- R7: While `ctl_enable` is 0, the next edge sets the count to 0 and discards all stored bytes.
- R8: While `tx_abort_raw` is 1, the next edge sets the count to 0 and discards all stored bytes.
- R9: While `slv_bulk_abort` is 1, the next edge sets the count to 0 and discards all stored bytes.
- R10: A flush takes priority over a push or pop in the same cycle. After the flush the count is 0, and the next byte written is the next byte popped.
- R11: Reading offset 0x74 returns the count in bits 6:0 with bits 31:7 zero. Every other read offset returns 0.
- R12: A register write to offset 0x74 has no effect on the count or the contents.
- R13: `q_empty` is 1 exactly when the count is 0, and `q_full` is 1 exactly when the count is 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_enable | input | 1 | Controller enable; 0 flushes the queue |
| tx_abort_raw | input | 1 | Raw transmit-abort status; 1 flushes the queue |
| slv_bulk_abort | input | 1 | Slave bulk-transmit abort; 1 flushes the queue |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wr_addr | input | 8 | Register write byte offset |
| bus_wr_data | input | 8 | Byte written to the queue |
| bus_rd_addr | input | 8 | Register read byte offset |
| bus_rd_data | output | 32 | Register read word (combinational) |
| shf_pop | input | 1 | Shifter takes the head byte |
| shf_data | output | 8 | Head byte of the queue |
| q_empty | output | 1 | Queue holds no bytes |
| q_full | output | 1 | Queue holds DEPTH bytes |

## Verification
Two pairs of functions can land on the same edge: a push with a pop, and a flush with a push or pop. The bench drives push and pop together at an empty queue, at a partly filled queue and at a full queue. In each case it judges the count against a reference queue in which full and empty are decided from the count before the edge. It also raises each of the three flush sources in a cycle that carries a push and a pop, then expects a count of zero. After that flush, the first byte written must be the next byte popped.

// File: rtl/txf_pkg.sv
// Package: shared encodings for the transmit byte queue.
// Assumes nothing beyond IEEE 1800-2017.
package txf_pkg;

    // Accepted operation on one clock edge, after full/empty gating.
    typedef enum logic [1:0] {
        TXF_IDLE = 2'b00,
        TXF_PUSH = 2'b01,
        TXF_POP  = 2'b10,
        TXF_BOTH = 2'b11
    } txf_op_e;

    // Width of a count that must hold 0..depth inclusive.
    function automatic int txf_cnt_w(input int depth);
        return $clog2(depth) + 1;
    endfunction

endpackage

// File: rtl/txf_level.sv
// Module: txf_level
// Keeps the occupancy count of the queue. Gates push/pop requests against
// full/empty and applies flush with top priority.
// Assumes: flush is already the OR of all clear sources; the count width can
// hold DEPTH itself.
module txf_level
    import txf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = txf_cnt_w(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [CNT_W-1:0] level,
    output logic             full,
    output logic             empty
);

    localparam logic [CNT_W-1:0] LVL_MAX = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LVL_ONE = CNT_W'(1);

    txf_op_e op;

    // Flags come straight from the count.
    always_comb begin
        full  = (level == LVL_MAX);
        empty = (level == '0);
    end

    // Accept a request only when space/data exists and no flush is active.
    always_comb begin
        push_ok = push_req && !full  && !flush;
        pop_ok  = pop_req  && !empty && !flush;
        op      = txf_op_e'({pop_ok, push_ok});
    end

    // Count update; reset and flush both return it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            level <= '0;
        end else begin
            unique case (op)
                TXF_PUSH: level <= level + LVL_ONE;
                TXF_POP:  level <= level - LVL_ONE;
                default:  level <= level;
            endcase
        end
    end

endmodule

// File: rtl/txf_store.sv
// Module: txf_store
// Byte storage with write and read pointers. The head entry is shown
// combinationally on rdata.
// Assumes: DEPTH is a power of two so the pointers wrap by overflow;
// push_ok/pop_ok are already gated against full/empty and flush.
module txf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push_ok,
    input  logic              pop_ok,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [DATA_W-1:0] mem [DEPTH];

    // Write pointer: advance on each stored byte, zero on reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
        end else if (push_ok) begin
            wr_ptr <= wr_ptr + PTR_W'(1);
        end
    end

    // Read pointer: advance on each removed byte, zero on reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
        end else if (pop_ok) begin
            rd_ptr <= rd_ptr + PTR_W'(1);
        end
    end

    // One write-enabled register per entry; contents need no reset.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push_ok && (wr_ptr == PTR_W'(gi))) begin
                mem[gi] <= wdata;
            end
        end
    end

    // Show the head byte.
    always_comb begin
        rdata = mem[rd_ptr];
    end

endmodule

// File: rtl/txf_regrd.sv
// Module: txf_regrd
// Read decode for the count word: zero-extended count at LVL_OFS, zero
// at every other offset.
// Assumes: BUS_DW is wider than CNT_W.
module txf_regrd #(
    parameter int           BUS_AW  = 8,
    parameter int           BUS_DW  = 32,
    parameter int           CNT_W   = 7,
    parameter logic [7:0]   LVL_OFS = 8'h74
) (
    input  logic [BUS_AW-1:0] rd_addr,
    input  logic [CNT_W-1:0]  level,
    output logic [BUS_DW-1:0] rd_data
);

    localparam int PAD_W = BUS_DW - CNT_W;

    // Select the count word or zero.
    always_comb begin
        if (rd_addr == BUS_AW'(LVL_OFS)) begin
            rd_data = {{PAD_W{1'b0}}, level};
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/tx_level_fifo.sv
// Module: tx_level_fifo
// Transmit byte queue of a serial controller: bus writes at DATA_OFS push,
// the shifter pops, and three controller events flush it. The count is
// readable at LVL_OFS.
// Assumes: synchronous active-low reset; DEPTH is a power of two.
module tx_level_fifo
    import txf_pkg::*;
#(
    parameter int         DATA_W   = 8,
    parameter int         DEPTH    = 64,
    parameter int         BUS_AW   = 8,
    parameter int         BUS_DW   = 32,
    parameter logic [7:0] DATA_OFS = 8'h10,
    parameter logic [7:0] LVL_OFS  = 8'h74
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_enable,
    input  logic              tx_abort_raw,
    input  logic              slv_bulk_abort,
    input  logic              bus_wr_en,
    input  logic [BUS_AW-1:0] bus_wr_addr,
    input  logic [DATA_W-1:0] bus_wr_data,
    input  logic [BUS_AW-1:0] bus_rd_addr,
    output logic [BUS_DW-1:0] bus_rd_data,
    input  logic              shf_pop,
    output logic [DATA_W-1:0] shf_data,
    output logic              q_empty,
    output logic              q_full
);

    localparam int CNT_W = txf_cnt_w(DEPTH);

    logic             flush;
    logic             push_req;
    logic             push_ok;
    logic             pop_ok;
    logic [CNT_W-1:0] level;

    // Any of the three controller events empties the queue.
    always_comb begin
        flush    = !ctl_enable || tx_abort_raw || slv_bulk_abort;
        push_req = bus_wr_en && (bus_wr_addr == BUS_AW'(DATA_OFS));
    end

    txf_level #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push_req (push_req),
        .pop_req  (shf_pop),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .level    (level),
        .full     (q_full),
        .empty    (q_empty)
    );

    txf_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .wdata   (bus_wr_data),
        .rdata   (shf_data)
    );

    txf_regrd #(
        .BUS_AW  (BUS_AW),
        .BUS_DW  (BUS_DW),
        .CNT_W   (CNT_W),
        .LVL_OFS (LVL_OFS)
    ) u_regrd (
        .rd_addr (bus_rd_addr),
        .level   (level),
        .rd_data (bus_rd_data)
    );

endmodule

// File: rtl/tx_level_fifo_chk.sv
// Module: tx_level_fifo_chk
// Temporal checks on the queue's ports, bound into tx_level_fifo.
module tx_level_fifo_chk #(
    parameter int         DEPTH    = 64,
    parameter int         BUS_AW   = 8,
    parameter int         BUS_DW   = 32,
    parameter logic [7:0] DATA_OFS = 8'h10,
    parameter logic [7:0] LVL_OFS  = 8'h74
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_enable,
    input logic              tx_abort_raw,
    input logic              slv_bulk_abort,
    input logic              bus_wr_en,
    input logic [BUS_AW-1:0] bus_wr_addr,
    input logic [BUS_AW-1:0] bus_rd_addr,
    input logic [BUS_DW-1:0] bus_rd_data,
    input logic              shf_pop,
    input logic              q_empty,
    input logic              q_full
);

    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic             clr;
    logic             wr_q;
    logic [CNT_W-1:0] lvl;

    // Observed request and count as seen on the ports.
    always_comb begin
        clr  = !ctl_enable || tx_abort_raw || slv_bulk_abort;
        wr_q = bus_wr_en && (bus_wr_addr == BUS_AW'(DATA_OFS));
        lvl  = bus_rd_data[CNT_W-1:0];
    end

    // R7 R8 R9
    flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q_empty);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && wr_q && !shf_pop && !clr) |=> q_full);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty && shf_pop && !wr_q && !clr) |=> q_empty);

    // R4
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_addr == BUS_AW'(LVL_OFS) && wr_q && shf_pop && !q_full
         && !q_empty && !clr && $stable(bus_rd_addr)) |=> $stable(lvl));

    // R13
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_empty && q_full));

    // R11
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_data[BUS_DW-1:CNT_W] == '0);

endmodule

bind tx_level_fifo tx_level_fifo_chk #(
    .DEPTH    (DEPTH),
    .BUS_AW   (BUS_AW),
    .BUS_DW   (BUS_DW),
    .DATA_OFS (DATA_OFS),
    .LVL_OFS  (LVL_OFS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_enable     (ctl_enable),
    .tx_abort_raw   (tx_abort_raw),
    .slv_bulk_abort (slv_bulk_abort),
    .bus_wr_en      (bus_wr_en),
    .bus_wr_addr    (bus_wr_addr),
    .bus_rd_addr    (bus_rd_addr),
    .bus_rd_data    (bus_rd_data),
    .shf_pop        (shf_pop),
    .q_empty        (q_empty),
    .q_full         (q_full)
);

// File: tb/tx_level_fifo_bench.sv
module tx_level_fifo_bench;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_enable = 1'b1;
    logic        tx_abort_raw = 1'b0;
    logic        slv_bulk_abort = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_wr_addr = 8'h00;
    logic [7:0]  bus_wr_data = 8'h00;
    logic [7:0]  bus_rd_addr = 8'h74;
    logic [31:0] bus_rd_data;
    logic        shf_pop = 1'b0;
    logic [7:0]  shf_data;
    logic        q_empty;
    logic        q_full;

    int total = 0;
    int bad = 0;
    logic [7:0] model[$];

    always #10 clk = ~clk;

    tx_level_fifo u_tx_level_fifo (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctl_enable     (ctl_enable),
        .tx_abort_raw   (tx_abort_raw),
        .slv_bulk_abort (slv_bulk_abort),
        .bus_wr_en      (bus_wr_en),
        .bus_wr_addr    (bus_wr_addr),
        .bus_wr_data    (bus_wr_data),
        .bus_rd_addr    (bus_rd_addr),
        .bus_rd_data    (bus_rd_data),
        .shf_pop        (shf_pop),
        .shf_data       (shf_data),
        .q_empty        (q_empty),
        .q_full         (q_full)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count word, flags and head byte against the reference queue.
    task automatic chk_state(input string req);
        int n = model.size();
        bus_rd_addr = 8'h74;
        #1;
        chk(bus_rd_data == 32'(n), req, int'(bus_rd_data), n);
        chk(q_empty == (n == 0), {req, "/R13 empty"}, int'(q_empty), int'(n == 0));
        chk(q_full == (n == DEPTH), {req, "/R13 full"}, int'(q_full), int'(n == DEPTH));
        if (n > 0) chk(shf_data == model[0], {req, "/R3 head"}, int'(shf_data), int'(model[0]));
    endtask

    // One cycle of stimulus; the reference decides from the count before the edge.
    task automatic cyc(input bit wr, input logic [7:0] wa, input logic [7:0] wd,
                       input bit pop, input bit en, input bit ab, input bit sb,
                       input string req);
        int n = model.size();
        bit clr = !en || ab || sb;
        bit pk = wr && (wa == 8'h10) && (n < DEPTH) && !clr;
        bit qk = pop && (n > 0) && !clr;
        bus_wr_en = wr; bus_wr_addr = wa; bus_wr_data = wd; shf_pop = pop;
        ctl_enable = en; tx_abort_raw = ab; slv_bulk_abort = sb;
        @(posedge clk); #1;
        bus_wr_en = 1'b0; shf_pop = 1'b0;
        ctl_enable = 1'b1; tx_abort_raw = 1'b0; slv_bulk_abort = 1'b0;
        if (clr) model.delete();
        else begin
            if (qk) void'(model.pop_front());
            if (pk) model.push_back(wd);
        end
        chk_state(req);
    endtask

    task automatic push(input logic [7:0] d, input string req);
        cyc(1'b1, 8'h10, d, 1'b0, 1'b1, 1'b0, 1'b0, req);
    endtask

    task automatic pop(input string req);
        cyc(1'b0, 8'h10, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, req);
    endtask

    task automatic flush_test(input int src, input int fill, input string req);
        for (int i = 0; i < fill; i++) push(8'(8'hA0 + i), req);
        cyc(1'b1, 8'h10, 8'h55, 1'b1, src != 0, src == 1, src == 2, req);
        push(8'h3C, "R10");
        chk(shf_data == 8'h3C, "R10 first byte after flush", int'(shf_data), 8'h3C);
        pop("R10");
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk_state("R1");
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk_state("R1");

        pop("R6");
        cyc(1'b1, 8'h10, 8'h11, 1'b1, 1'b1, 1'b0, 1'b0, "R4 empty both");

        for (int i = 1; i < DEPTH; i++) push(8'(i * 3 + 1), "R2");
        chk_state("R5 at depth");
        push(8'hEE, "R5");
        cyc(1'b1, 8'h10, 8'hEF, 1'b1, 1'b1, 1'b0, 1'b0, "R4 full both");
        cyc(1'b1, 8'h74, 8'h99, 1'b0, 1'b1, 1'b0, 1'b0, "R12");

        for (int i = 0; i < 20; i++) pop("R3");
        for (int i = 0; i < 10; i++)
            cyc(1'b1, 8'h10, 8'(8'hC0 + i), 1'b1, 1'b1, 1'b0, 1'b0, "R4");
        cyc(1'b1, 8'h74, 8'h77, 1'b1, 1'b1, 1'b0, 1'b0, "R12 with pop");

        for (int a = 0; a < 256; a++) begin
            bus_rd_addr = 8'(a);
            #1;
            if (a == 8'h74)
                chk(bus_rd_data == 32'(model.size()), "R11", int'(bus_rd_data), model.size());
            else
                chk(bus_rd_data == 32'd0, "R11 other", int'(bus_rd_data), 0);
        end

        while (model.size() > 0) pop("R3 drain");
        pop("R6");

        flush_test(0, 5, "R7");
        flush_test(1, 17, "R8");
        flush_test(2, 64, "R9");
        flush_test(0, 0, "R7 empty");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule